// File: doc/BRIEF.md
# Endpoint configuration command unit

This unit holds the per-endpoint configuration of a full-speed USB device controller and answers the configuration commands that the local microcontroller issues. A command strobe latches a code byte. One data strobe that follows moves one configuration byte into or out of the addressed endpoint register. The unit covers sixteen endpoints: the control OUT endpoint, the control IN endpoint, then endpoints 1 to 14.

The shared FIFO buffer memory is partitioned only after the firmware has written all sixteen registers in strict endpoint order. At that point the unit assigns each enabled endpoint a base and a byte length by accumulating buffer sizes, raises a memory-valid flag, and reports whether the buffers fit in the memory. Changing the size, the double buffering or the enable of any endpoint drops memory-valid, because the buffered data of all endpoints is then lost. A USB bus-reset pulse disables every endpoint.

Top module: `ep_cfg_unit`

## Requirements
- R1: A command strobe with code 0x20+k (k = 0..15), followed by one data strobe, stores data bits 7:0 into endpoint register k. Register 0 is control OUT, register 1 is control IN, and register k+1 is endpoint k. The data strobe consumes the command, and bits above 7 of the data word are ignored.
- R2: A command strobe with code 0x30+k makes data_out[7:0] show register k until a read data strobe consumes the command. Bits above 7 of data_out are always zero.
- R3: Registers 2..15 keep the byte exactly as written, with bit 0 enable, bit 1 direction IN, bit 2 double buffered, bit 3 isochronous, bits 6:4 size code and bit 7 spare.
- R4: Register 0 always stores 0x31 and register 1 always stores 0x33 when written, whatever the data byte.
- R5: When a write to register 15 completes an ordered pass 0,1,...,15, mem_valid rises on the clock edge after the edge that stores register 15. It does not rise at the edge that stores it.
- R6: At allocation, each endpoint's length is 0 if it is disabled, and otherwise (8 << size code), doubled when double buffered. The base of endpoint 0 is 0, and the base of each later endpoint is the sum of the lengths before it.
- R7: alloc_ovf is set at allocation exactly when the sum of all lengths exceeds MEM_BYTES (2048 by default). A sum equal to MEM_BYTES is not an overflow.
- R8: A write to any register other than the next expected one restarts the ordered pass. A write to register 0 restarts it with register 0 already counted. A pass broken this way does not raise mem_valid.
- R9: A write that changes the enable, double-buffer or size bits of any register clears mem_valid on that edge. A write that changes only the direction, type or spare bits leaves mem_valid unchanged.
- R10: A bus_reset pulse clears every enable bit, mem_valid, alloc_ovf and the pass progress. All other configuration bits are kept.
- R11: A data strobe with no matching pending command, and any command code outside 0x20..0x3F, change no register. data_out is zero while no read is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command strobe, code in data_in[7:0] |
| dat_wr | input | 1 | Data write strobe |
| dat_rd | input | 1 | Data read strobe, ends a pending read |
| data_in | input | DATA_W | Command code or data byte in bits 7:0 |
| data_out | output | DATA_W | Read data of the pending read command |
| bus_reset | input | 1 | One-cycle USB bus-reset pulse |
| ep_base | output | 16*SUM_W | Allocated base per endpoint, endpoint k at bits k*SUM_W |
| ep_len | output | 16*SUM_W | Allocated byte length per endpoint |
| mem_valid | output | 1 | Partition is valid |
| alloc_ovf | output | 1 | Allocated total exceeds MEM_BYTES |

## Verification
The assertions assume strobes are single-cycle pulses that never coincide with one another, and that bus_reset never lands in the same cycle as a data write. Under those assumptions every rise or fall of mem_valid has exactly one cause. The stimulus issues each strobe from its own task, with at least one idle negedge between strobes. After each write to register 15 it inserts an idle cycle, and it pulses bus_reset only when no command traffic is active. Random configuration bytes exercise all size codes, so the allocation sum lands both inside and beyond the memory.

// File: rtl/ep_cfg_pkg.sv
package ep_cfg_pkg;
    localparam int NUM_EP    = 16;
    localparam int IDX_W     = 4;
    localparam int CODE_W    = 3;
    localparam int SIZE_UNIT = 8;

    typedef struct packed {
        logic              spare;
        logic [CODE_W-1:0] size_code;
        logic              iso;
        logic              dbl;
        logic              dir_in;
        logic              en;
    } ep_cfg_t;

    localparam logic [7:0] CTL_OUT_CFG = 8'h31;
    localparam logic [7:0] CTL_IN_CFG  = 8'h33;

    function automatic logic alloc_changes(ep_cfg_t a, ep_cfg_t b);
        return (a.en != b.en) || (a.dbl != b.dbl) || (a.size_code != b.size_code);
    endfunction
endpackage

// File: rtl/ep_cmd_decode.sv
module ep_cmd_decode
    import ep_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic             dat_wr,
    input  logic             dat_rd,
    input  logic [7:0]       code,
    output logic             wr_fire,
    output logic             rd_active,
    output logic [IDX_W-1:0] sel_idx
);
    typedef struct packed {
        logic             valid;
        logic             is_wr;
        logic [IDX_W-1:0] idx;
    } pend_t;

    pend_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        wr_fire = !cmd_wr && dat_wr && st_q.valid && st_q.is_wr;
        if (cmd_wr) begin
            st_d.valid = (code[7:5] == 3'b001);
            st_d.is_wr = ~code[4];
            st_d.idx   = code[IDX_W-1:0];
        end else if (wr_fire || (dat_rd && st_q.valid && !st_q.is_wr)) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_active = st_q.valid && !st_q.is_wr;
    assign sel_idx   = st_q.idx;
endmodule

// File: rtl/ep_alloc_calc.sv
module ep_alloc_calc
    import ep_cfg_pkg::*;
#(
    parameter int SUM_W = 16
) (
    input  ep_cfg_t [NUM_EP-1:0]            cfg,
    output logic    [NUM_EP-1:0][SUM_W-1:0] base,
    output logic    [NUM_EP-1:0][SUM_W-1:0] len,
    output logic    [SUM_W-1:0]             total
);
    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        assign len[i] = cfg[i].en
                      ? ((SUM_W'(SIZE_UNIT) << cfg[i].size_code) << cfg[i].dbl)
                      : '0;
        if (i == 0) begin : g_first
            assign base[i] = '0;
        end else begin : g_next
            assign base[i] = base[i-1] + len[i-1];
        end
    end

    assign total = base[NUM_EP-1] + len[NUM_EP-1];
endmodule

// File: rtl/ep_cfg_unit.sv
module ep_cfg_unit
    import ep_cfg_pkg::*;
#(
    parameter int MEM_BYTES = 2048,
    parameter int DATA_W    = 16,
    localparam int MAX_BYTES = 2 * (SIZE_UNIT << ((1 << CODE_W) - 1)),
    localparam int SUM_W     = $clog2(NUM_EP * MAX_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_wr,
    input  logic                    dat_wr,
    input  logic                    dat_rd,
    input  logic [DATA_W-1:0]       data_in,
    output logic [DATA_W-1:0]       data_out,
    input  logic                    bus_reset,
    output logic [NUM_EP*SUM_W-1:0] ep_base,
    output logic [NUM_EP*SUM_W-1:0] ep_len,
    output logic                    mem_valid,
    output logic                    alloc_ovf
);
    typedef struct packed {
        ep_cfg_t [NUM_EP-1:0]            cfg;
        logic    [IDX_W-1:0]             seq;
        logic                            alloc_pend;
        logic                            mem_valid;
        logic                            ovf;
        logic    [NUM_EP-1:0][SUM_W-1:0] base;
        logic    [NUM_EP-1:0][SUM_W-1:0] len;
    } state_t;

    state_t st_d, st_q;

    logic                            wr_fire;
    logic                            rd_active;
    logic [IDX_W-1:0]                sel_idx;
    logic [NUM_EP-1:0][SUM_W-1:0]    calc_base;
    logic [NUM_EP-1:0][SUM_W-1:0]    calc_len;
    logic [SUM_W-1:0]                calc_total;
    logic [NUM_EP-1:0]               en_vec;
    ep_cfg_t                         new_cfg;

    ep_cmd_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .dat_wr    (dat_wr),
        .dat_rd    (dat_rd),
        .code      (data_in[7:0]),
        .wr_fire   (wr_fire),
        .rd_active (rd_active),
        .sel_idx   (sel_idx)
    );

    ep_alloc_calc #(.SUM_W(SUM_W)) u_calc (
        .cfg   (st_q.cfg),
        .base  (calc_base),
        .len   (calc_len),
        .total (calc_total)
    );

    always_comb begin
        case (sel_idx)
            IDX_W'(0): new_cfg = ep_cfg_t'(CTL_OUT_CFG);
            IDX_W'(1): new_cfg = ep_cfg_t'(CTL_IN_CFG);
            default:   new_cfg = ep_cfg_t'(data_in[7:0]);
        endcase
    end

    always_comb begin
        st_d = st_q;
        // allocation one edge after the pass completes
        if (st_q.alloc_pend) begin
            st_d.base       = calc_base;
            st_d.len        = calc_len;
            st_d.mem_valid  = 1'b1;
            st_d.ovf        = (calc_total > SUM_W'(MEM_BYTES));
            st_d.alloc_pend = 1'b0;
        end
        if (wr_fire) begin
            if (alloc_changes(new_cfg, st_q.cfg[sel_idx])) begin
                st_d.mem_valid  = 1'b0;
                st_d.alloc_pend = 1'b0;
            end
            st_d.cfg[sel_idx] = new_cfg;
            if (sel_idx == st_q.seq) begin
                if (sel_idx == IDX_W'(NUM_EP - 1)) begin
                    st_d.seq        = '0;
                    st_d.alloc_pend = 1'b1;
                end else begin
                    st_d.seq = st_q.seq + 1'b1;
                end
            end else begin
                st_d.seq = (sel_idx == '0) ? IDX_W'(1) : '0;
            end
        end
        if (bus_reset) begin
            for (int i = 0; i < NUM_EP; i++) st_d.cfg[i].en = 1'b0;
            st_d.mem_valid  = 1'b0;
            st_d.ovf        = 1'b0;
            st_d.alloc_pend = 1'b0;
            st_d.seq        = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int i = 0; i < NUM_EP; i++) en_vec[i] = st_q.cfg[i].en;
    end

    if (DATA_W > 8) begin : g_wide
        logic unused_hi;
        assign unused_hi = ^data_in[DATA_W-1:8];
        assign data_out  = {{(DATA_W-8){1'b0}}, rd_active ? st_q.cfg[sel_idx] : 8'h00};
    end else begin : g_narrow
        assign data_out  = rd_active ? st_q.cfg[sel_idx] : 8'h00;
    end

    assign ep_base   = st_q.base;
    assign ep_len    = st_q.len;
    assign mem_valid = st_q.mem_valid;
    assign alloc_ovf = st_q.ovf;
endmodule

// File: rtl/ep_cfg_chk.sv
module ep_cfg_chk
    import ep_cfg_pkg::*;
#(
    parameter int SUM_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_reset,
    input logic                    wr_fire,
    input logic [IDX_W-1:0]        wr_idx,
    input logic                    mem_valid,
    input logic [NUM_EP-1:0]       en_vec,
    input logic [NUM_EP*SUM_W-1:0] ep_base,
    input logic [NUM_EP*SUM_W-1:0] ep_len
);
    // R5
    rose_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_valid) |-> $past(wr_fire && (wr_idx == IDX_W'(NUM_EP - 1)), 2));

    // R10
    reset_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !mem_valid);

    // R10
    reset_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (en_vec == '0));

    // R9
    fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_valid) |-> $past(bus_reset || wr_fire));

    // R4
    ctl_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && (wr_idx < IDX_W'(2)) && !bus_reset) |=> en_vec[$past(wr_idx)]);

    // R6
    first_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (ep_base[SUM_W-1:0] == '0));

    for (genvar i = 1; i < NUM_EP; i++) begin : g_pack
        // R6
        contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mem_valid |-> (ep_base[i*SUM_W +: SUM_W] ==
                           ep_base[(i-1)*SUM_W +: SUM_W] + ep_len[(i-1)*SUM_W +: SUM_W]));
    end
endmodule

bind ep_cfg_unit ep_cfg_chk #(.SUM_W(SUM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_reset (bus_reset),
    .wr_fire   (wr_fire),
    .wr_idx    (sel_idx),
    .mem_valid (mem_valid),
    .en_vec    (en_vec),
    .ep_base   (ep_base),
    .ep_len    (ep_len)
);

// File: tb/tb_ep_cfg_unit.sv
module tb_ep_cfg_unit;
    localparam int SW  = 16;
    localparam int MEM = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0, dat_wr = 1'b0, dat_rd = 1'b0, bus_reset = 1'b0;
    logic [15:0] data_in = '0;
    logic [15:0] data_out;
    logic [16*SW-1:0] ep_base, ep_len;
    logic        mem_valid, alloc_ovf;

    ep_cfg_unit dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .dat_wr(dat_wr), .dat_rd(dat_rd),
        .data_in(data_in), .data_out(data_out), .bus_reset(bus_reset),
        .ep_base(ep_base), .ep_len(ep_len), .mem_valid(mem_valid), .alloc_ovf(alloc_ovf)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [7:0] m_cfg [16];
    int  m_seq = 0;
    bit  m_valid = 0, m_ovf = 0;
    int  m_base [16], m_len [16];

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    function automatic int len_of(logic [7:0] v);
        if (!v[0]) return 0;
        return (8 << v[6:4]) * (v[2] ? 2 : 1);
    endfunction

    task automatic pulse_cmd(logic [7:0] code);
        @(negedge clk);
        cmd_wr  = 1'b1;
        data_in = {8'($urandom), code};
        @(negedge clk);
        cmd_wr  = 1'b0;
    endtask

    task automatic pulse_wr(logic [7:0] v);
        @(negedge clk);
        dat_wr  = 1'b1;
        data_in = {8'($urandom), v};
        @(negedge clk);
        dat_wr  = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    // write endpoint register k and advance the reference model
    task automatic wr_ep(int k, logic [7:0] v);
        logic [7:0] nv;
        bit pend = 0;
        int tot = 0;
        pulse_cmd(8'h20 + 8'(k));
        pulse_wr(v);
        nv = (k == 0) ? 8'h31 : (k == 1) ? 8'h33 : v;
        if (nv[0] != m_cfg[k][0] || nv[2] != m_cfg[k][2] || nv[6:4] != m_cfg[k][6:4])
            m_valid = 0;
        m_cfg[k] = nv;
        if (k == m_seq) begin
            if (k == 15) begin m_seq = 0; pend = 1; end
            else m_seq++;
        end else begin
            m_seq = (k == 0) ? 1 : 0;
        end
        if (pend) begin
            // R5: not yet valid at the edge that stores register 15
            if (!m_valid) chk(mem_valid == 1'b0, "R5 early", int'(mem_valid), 0);
            idle();
            for (int i = 0; i < 16; i++) begin
                m_len[i]  = len_of(m_cfg[i]);
                m_base[i] = tot;
                tot += m_len[i];
            end
            m_valid = 1;
            m_ovf   = (tot > MEM);
        end
    endtask

    task automatic rd_ep(int k, output logic [7:0] got);
        pulse_cmd(8'h30 + 8'(k));
        @(negedge clk);
        dat_rd = 1'b1;
        #1;
        got = data_out[7:0];
        chk(data_out[15:8] == 8'h00, "R2 upper", int'(data_out[15:8]), 0);
        @(negedge clk);
        dat_rd = 1'b0;
    endtask

    task automatic check_regs(string req);
        logic [7:0] g;
        for (int k = 0; k < 16; k++) begin
            rd_ep(k, g);
            chk(g == m_cfg[k], req, int'(g), int'(m_cfg[k]));
        end
    endtask

    task automatic check_alloc(string req);
        chk(mem_valid == m_valid, {req, " valid"}, int'(mem_valid), int'(m_valid));
        chk(alloc_ovf == m_ovf, "R7 ovf", int'(alloc_ovf), int'(m_ovf));
        if (m_valid) begin
            for (int i = 0; i < 16; i++) begin
                chk(int'(ep_base[i*SW +: SW]) == m_base[i], "R6 base", int'(ep_base[i*SW +: SW]), m_base[i]);
                chk(int'(ep_len[i*SW +: SW]) == m_len[i], "R6 len", int'(ep_len[i*SW +: SW]), m_len[i]);
            end
        end
    endtask

    task automatic full_pass(logic [7:0] v [16]);
        for (int k = 0; k < 16; k++) wr_ep(k, v[k]);
    endtask

    task automatic do_bus_reset();
        @(negedge clk);
        bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
        for (int i = 0; i < 16; i++) m_cfg[i][0] = 1'b0;
        m_valid = 0; m_ovf = 0; m_seq = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [7:0] v [16];
        logic [7:0] g;
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        for (int i = 0; i < 16; i++) m_cfg[i] = 8'h00;

        repeat (3) idle();
        rst_n = 1'b1;
        idle();

        // reset state
        chk(mem_valid == 1'b0, "R5 reset", int'(mem_valid), 0);
        chk(alloc_ovf == 1'b0, "R7 reset", int'(alloc_ovf), 0);
        chk(data_out == 16'h0, "R11 idle out", int'(data_out), 0);
        check_regs("R2 reset readback");

        // directed exact fit: 64+64+1024+512+256+128 = 2048
        v[0] = 8'hFF; v[1] = 8'h00;
        v[2] = 8'h71; v[3] = 8'h63; v[4] = 8'h59; v[5] = 8'h41;
        for (int k = 6; k < 16; k++) v[k] = 8'h7E;
        full_pass(v);
        check_alloc("R5 fit");
        chk(alloc_ovf == 1'b0, "R7 exact fit", int'(alloc_ovf), 0);
        check_regs("R3 R4 readback");

        // one more 8-byte endpoint tips over
        v[6] = 8'h01;
        full_pass(v);
        check_alloc("R5 over");
        chk(alloc_ovf == 1'b1, "R7 one over", int'(alloc_ovf), 1);

        // R9: direction and type only keep validity
        wr_ep(6, 8'h03);
        chk(mem_valid == 1'b1, "R9 dir change", int'(mem_valid), 1);
        wr_ep(6, 8'h8B);
        chk(mem_valid == 1'b1, "R9 type/spare change", int'(mem_valid), 1);
        wr_ep(6, 8'h8F);
        chk(mem_valid == 1'b0, "R9 dbl change", int'(mem_valid), 0);

        // R8: broken pass (skips register 9)
        for (int k = 0; k < 16; k++) if (k != 9) wr_ep(k, v[k]);
        chk(mem_valid == 1'b0, "R8 skipped", int'(mem_valid), 0);
        // R8: restart at register 0 midway
        for (int k = 0; k < 6; k++) wr_ep(k, v[k]);
        full_pass(v);
        check_alloc("R8 restart");

        // R11: stray data strobe, bad code, write on read command
        pulse_wr(8'hFF);
        pulse_cmd(8'h47);
        pulse_wr(8'hFF);
        pulse_cmd(8'h1F);
        pulse_wr(8'hFF);
        pulse_cmd(8'h33);
        pulse_wr(8'h00);
        @(negedge clk);
        dat_rd = 1'b1;
        #1;
        chk(data_out[7:0] == m_cfg[3], "R11 read survives write strobe", int'(data_out[7:0]), int'(m_cfg[3]));
        @(negedge clk);
        dat_rd = 1'b0;
        #1;
        chk(data_out == 16'h0, "R11 idle out", int'(data_out), 0);
        check_regs("R11 no change");
        check_alloc("R11 alloc kept");

        // R10: bus reset
        do_bus_reset();
        check_alloc("R10 reset");
        check_regs("R10 enables cleared");

        // random passes (R1 R3 R6 R7)
        for (int p = 0; p < 40; p++) begin
            for (int k = 0; k < 16; k++) v[k] = 8'($urandom);
            full_pass(v);
            check_alloc("R1 random pass");
            if (p % 8 == 0) check_regs("R3 random readback");
            if (p % 10 == 5) begin
                do_bus_reset();
                check_alloc("R10 random reset");
            end
        end

        report();
    end
endmodule